// File: doc/BRIEF.md
# Supply and Thermal Fault Supervisor

This block turns digitized readings of one input-side supply, two output-side supplies and the die temperature into qualified health flags. They drive the interlock of a two-channel isolated gate driver. Supply readings are unsigned millivolt codes and temperature is an unsigned code in degrees Celsius.

Each supply passes through a hysteretic comparator. Its qualification is then held back by a power-up settle counter, and any dropout restarts that counter. The output-side thresholds come from a three-way grade setting, which is captured while reset is held. A latching over-temperature detector overrides everything: once the die is hot, both channel enables stay low until the die has cooled well below the entry point.

The downstream interlock uses the input-side good flag, the two per-channel enables and the over-temperature flag.

Top module: `fault_supervisor`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `in_good`, `en_a`, `en_b` and `over_temp` are all 0, whatever the readings are.
- R2: The input-side supply qualifies only when `vin_mv` is strictly above 2450. It disqualifies only when `vin_mv` is strictly below 2350. Readings from 2350 to 2450 inclusive keep the previous state.
- R3: A channel supply qualifies when its reading is strictly above the rising threshold of the captured grade, and disqualifies when it is strictly below the falling threshold.
  - Grade code 0: rising 4400, falling 4200.
  - Grade code 1: rising 7300, falling 7100.
  - Grade code 2: rising 11300, falling 11100.
  - Grade code 3 is treated as code 2.
- R4: `grade_sel` is sampled only while `rst_n` is low. Changing it after reset is released has no effect on the thresholds.
- R5: Take a reading that first exceeds its rising threshold before clock edge E0. Its good flag reads 1 only after edge E0+SETTLE_CYC, provided it has not fallen below the falling threshold in between. A reading below the falling threshold clears the flag at the next edge and restarts the settle count.
- R6: `over_temp` sets at the edge after `temp_c` is strictly above 155. Once set, it clears only at the edge after `temp_c` is strictly below 125.
- R7: `en_a` equals `in_good` AND the channel A good flag AND NOT `over_temp`. `en_b` is formed the same way from the channel B good flag.
- R8: Channels A and B are qualified independently: one channel's reading never changes the other channel's enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; grade is captured while low |
| grade_sel | input | 2 | Output-side threshold grade (0, 1, 2; 3 acts as 2) |
| vin_mv | input | VW | Input-side supply reading, mV |
| va_mv | input | VW | Channel A output-side supply reading, mV |
| vb_mv | input | VW | Channel B output-side supply reading, mV |
| temp_c | input | TW | Die temperature reading, degrees C |
| in_good | output | 1 | Input-side supply qualified and settled |
| en_a | output | 1 | Channel A drive enable |
| en_b | output | 1 | Channel B drive enable |
| over_temp | output | 1 | Thermal shutdown latched |

## Verification
On every cycle, the assertions check four things:
- the input-side dropout response;
- that a rising `in_good` was backed by an in-hysteresis reading;
- the entry, hold and no-spontaneous-set rules of the thermal latch;
- that an enable never coexists with a bad input side or an over-temperature state.

Only the bench scenarios can show the following:
- the exact settle latency and its restart after a short dropout;
- the per-grade threshold boundaries, including the equal-to-threshold cases;
- that grade changes after reset are ignored;
- that the two channels are independent.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        GR_LOW  = 2'd0,
        GR_MID  = 2'd1,
        GR_HIGH = 2'd2
    } grade_e;

    localparam int unsigned IN_RISE_MV = 2450;
    localparam int unsigned IN_FALL_MV = 2350;
    localparam int unsigned HOT_ENTER_C = 155;
    localparam int unsigned HOT_EXIT_C  = 125;

    function automatic grade_e map_grade(input logic [1:0] code);
        grade_e g;
        case (code)
            2'd0:    g = GR_LOW;
            2'd1:    g = GR_MID;
            default: g = GR_HIGH;
        endcase
        return g;
    endfunction

    function automatic int unsigned rise_mv(input grade_e g);
        int unsigned v;
        case (g)
            GR_LOW:  v = 4400;
            GR_MID:  v = 7300;
            default: v = 11300;
        endcase
        return v;
    endfunction

    function automatic int unsigned fall_mv(input grade_e g);
        return rise_mv(g) - 200;
    endfunction

endpackage

// File: rtl/level_qualifier.sv
module level_qualifier #(
    parameter int unsigned W      = 16,
    parameter int unsigned SETTLE = 2800
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] rise_th,
    input  logic [W-1:0] fall_th,
    output logic         good
);
    localparam int unsigned CW = $clog2(SETTLE + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(SETTLE);

    typedef struct packed {
        logic          ok;
        logic [CW-1:0] cnt;
    } qual_t;

    qual_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.ok && (level > rise_th)) begin
            st_d.ok = 1'b1;
        end else if (st_q.ok && (level < fall_th)) begin
            st_d.ok = 1'b0;
        end
        if (!st_q.ok) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (!st_d.ok) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign good = st_q.ok && (st_q.cnt == CNT_MAX);
endmodule

// File: rtl/thermal_latch.sv
module thermal_latch #(
    parameter int unsigned TW    = 8,
    parameter int unsigned ENTER = 155,
    parameter int unsigned EXIT  = 125
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] temp,
    output logic          hot
);
    localparam logic [TW-1:0] ENTER_T = TW'(ENTER);
    localparam logic [TW-1:0] EXIT_T  = TW'(EXIT);

    typedef struct packed {
        logic hot;
    } th_t;

    th_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.hot && (temp > ENTER_T)) begin
            st_d.hot = 1'b1;
        end else if (st_q.hot && (temp < EXIT_T)) begin
            st_d.hot = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hot = st_q.hot;
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
    import sup_pkg::*;
#(
    parameter int unsigned VW         = 16,
    parameter int unsigned TW         = 8,
    parameter int unsigned SETTLE_CYC = 2800
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    grade_sel,
    input  logic [VW-1:0] vin_mv,
    input  logic [VW-1:0] va_mv,
    input  logic [VW-1:0] vb_mv,
    input  logic [TW-1:0] temp_c,
    output logic          in_good,
    output logic          en_a,
    output logic          en_b,
    output logic          over_temp
);
    localparam int unsigned NCH = 2;

    typedef struct packed {
        grade_e grade;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [VW-1:0] out_rise, out_fall;
    logic [VW-1:0] ch_level [NCH];
    logic [NCH-1:0] ch_good;
    logic hot;

    always_comb begin
        cfg_d = cfg_q;
        if (!rst_n) begin
            cfg_d.grade = map_grade(grade_sel);
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    always_comb begin
        out_rise = VW'(rise_mv(cfg_q.grade));
        out_fall = VW'(fall_mv(cfg_q.grade));
    end

    level_qualifier #(.W(VW), .SETTLE(SETTLE_CYC)) u_in_q (
        .clk(clk), .rst_n(rst_n), .level(vin_mv),
        .rise_th(VW'(IN_RISE_MV)), .fall_th(VW'(IN_FALL_MV)),
        .good(in_good)
    );

    assign ch_level[0] = va_mv;
    assign ch_level[1] = vb_mv;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        level_qualifier #(.W(VW), .SETTLE(SETTLE_CYC)) u_ch_q (
            .clk(clk), .rst_n(rst_n), .level(ch_level[c]),
            .rise_th(out_rise), .fall_th(out_fall),
            .good(ch_good[c])
        );
    end

    thermal_latch #(.TW(TW), .ENTER(HOT_ENTER_C), .EXIT(HOT_EXIT_C)) u_hot (
        .clk(clk), .rst_n(rst_n), .temp(temp_c), .hot(hot)
    );

    assign over_temp = hot;
    assign en_a = in_good && ch_good[0] && !hot;
    assign en_b = in_good && ch_good[1] && !hot;
endmodule

// File: rtl/sup_checker.sv
module sup_checker
    import sup_pkg::*;
#(
    parameter int unsigned VW = 16,
    parameter int unsigned TW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [VW-1:0] vin_mv,
    input logic [TW-1:0] temp_c,
    input logic          in_good,
    input logic          en_a,
    input logic          en_b,
    input logic          over_temp
);
    a_r2_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (in_good && (vin_mv < VW'(IN_FALL_MV))) |=> !in_good);

    a_r2_rise_backed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_good) |-> ($past(vin_mv) >= VW'(IN_FALL_MV)));

    a_r6_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_c > TW'(HOT_ENTER_C)) |=> over_temp);

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (over_temp && (temp_c >= TW'(HOT_EXIT_C))) |=> over_temp);

    a_r6_no_false_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!over_temp && (temp_c <= TW'(HOT_ENTER_C))) |=> !over_temp);

    a_r7_en_a_gated: assert property (@(posedge clk) disable iff (!rst_n)
        en_a |-> (in_good && !over_temp));

    a_r7_en_b_gated: assert property (@(posedge clk) disable iff (!rst_n)
        en_b |-> (in_good && !over_temp));
endmodule

bind fault_supervisor sup_checker #(.VW(VW), .TW(TW)) u_sup_chk (
    .clk(clk), .rst_n(rst_n), .vin_mv(vin_mv), .temp_c(temp_c),
    .in_good(in_good), .en_a(en_a), .en_b(en_b), .over_temp(over_temp)
);

// File: tb/tb_fault_supervisor.sv
module tb_fault_supervisor;
    localparam int unsigned S = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] grade_sel = 2'd1;
    logic [15:0] vin_mv = '0, va_mv = '0, vb_mv = '0;
    logic [7:0] temp_c = 8'd25;
    logic in_good, en_a, en_b, over_temp;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fault_supervisor #(.VW(16), .TW(8), .SETTLE_CYC(S)) dut (
        .clk(clk), .rst_n(rst_n), .grade_sel(grade_sel),
        .vin_mv(vin_mv), .va_mv(va_mv), .vb_mv(vb_mv), .temp_c(temp_c),
        .in_good(in_good), .en_a(en_a), .en_b(en_b), .over_temp(over_temp)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_rise(input int g);
        return (g == 0) ? 4400 : (g == 1) ? 7300 : 11300;
    endfunction

    function automatic int exp_fall(input int g);
        return (g == 0) ? 4200 : (g == 1) ? 7100 : 11100;
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, even with good readings present
        vin_mv = 16'd3300; va_mv = 16'd9000; vb_mv = 16'd9000; temp_c = 8'd200;
        tick(3);
        chk("R1 in_good", in_good, 0);
        chk("R1 en_a", en_a, 0);
        chk("R1 en_b", en_b, 0);
        chk("R1 over_temp", over_temp, 0);
        vin_mv = '0; va_mv = '0; vb_mv = '0; temp_c = 8'd25;
        rst_n = 1'b1;
        tick(1);
        chk("R1 after release", in_good, 0);

        // R2: equal to the rising threshold does not qualify
        vin_mv = 16'd2450; tick(10);
        chk("R2 at rise", in_good, 0);
        // R5: settle latency
        vin_mv = 16'd2451; tick(S);
        chk("R5 before settle", in_good, 0);
        tick(1);
        chk("R5 settled", in_good, 1);
        // R2: hysteresis band holds
        vin_mv = 16'd2350; tick(10);
        chk("R2 at fall holds", in_good, 1);
        vin_mv = 16'd2349; tick(1);
        chk("R2 below fall", in_good, 0);
        // R5: restart after short dropout
        vin_mv = 16'd2451; tick(S - 1);
        vin_mv = 16'd2349; tick(1);
        chk("R5 dropout", in_good, 0);
        vin_mv = 16'd2451; tick(S);
        chk("R5 restart pending", in_good, 0);
        tick(1);
        chk("R5 restart done", in_good, 1);

        // R3 / R4 / R8: grade sweep
        for (int g = 0; g < 4; g++) begin
            int gi, r, f;
            gi = (g == 3) ? 2 : g;
            r = exp_rise(gi);
            f = exp_fall(gi);
            rst_n = 1'b0; grade_sel = 2'(g); va_mv = '0; vb_mv = '0;
            tick(2);
            rst_n = 1'b1;
            grade_sel = 2'(3 - g);
            vin_mv = 16'd3300;
            va_mv = 16'(r); tick(S + 2);
            chk("R3 a at rise", en_a, 0);
            va_mv = 16'(r + 1); tick(S);
            chk("R5 a pending", en_a, 0);
            tick(1);
            chk("R3 a above rise", en_a, 1);
            if (g == 0) chk("R4 grade change ignored", en_a, 1);
            chk("R8 b unaffected", en_b, 0);
            chk("R7 in_good", in_good, 1);
            va_mv = 16'(f); tick(S + 2);
            chk("R3 a at fall holds", en_a, 1);
            va_mv = 16'(f - 1); tick(1);
            chk("R3 a below fall", en_a, 0);
            vb_mv = 16'(r + 1); tick(S + 1);
            chk("R8 b up", en_b, 1);
            chk("R8 a stays down", en_a, 0);
        end

        // R6 / R7: thermal latch
        temp_c = 8'd155; tick(2);
        chk("R6 at enter", over_temp, 0);
        chk("R7 en_b cool", en_b, 1);
        temp_c = 8'd156; tick(1);
        chk("R6 entered", over_temp, 1);
        chk("R7 en_b hot", en_b, 0);
        temp_c = 8'd125; tick(3);
        chk("R6 at exit holds", over_temp, 1);
        temp_c = 8'd124; tick(1);
        chk("R6 exited", over_temp, 0);
        chk("R7 en_b back", en_b, 1);
        vin_mv = 16'd2000; tick(1);
        chk("R7 input side fail", en_b, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule